// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers hardware event pulses from eleven second-level interrupt groups and folds them into one top-level master register. Each group has four 32-bit word registers:

- a live status view of its event inputs;
- a mask that decides which events may latch;
- an identity register that holds latched pending events and is cleared by writing ones;
- an enable register that selects which pending bits count toward the summary.

The enabled pending bits of each group drive summary bits in the master register. The first four groups are engine groups. Some of them report their low and high 16-bit halves on separate master bits.

Software reaches every register over a plain 32-bit read/write bus. Reads have zero wait states. Master bit 31 is the only software-writable master bit and acts as the global enable. When that enable is set, at least one summary bit is set, and the message control word is in its single legal enabled form, the block issues a one-cycle interrupt request pulse. The pulse fires on each rising edge of that combined condition.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every mask register reads 0xFFFFFFFF. Every identity register, enable register and the master register read 0, and `irq_pulse` is 0.
- R2: An event pulse on bit b of group g sets identity bit b at the next clock edge only if mask bit b is 0. A masked event is dropped and does not appear after a later unmask.
- R3: A write to an identity register clears each bit written as 1 and leaves bits written as 0 unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R4: A write to a mask or enable register replaces its whole value, and reading it back returns that value.
- R5: Master summary bits are levels of (identity AND enable), set and cleared with no latching. The mapping is:
  - bit 0 = any of group 0 bits 15:0; bit 1 = group 0 bits 31:16;
  - bit 2 = group 1 bits 15:0; bit 3 = group 1 bits 31:16;
  - bit 4 = group 2 bits 15:0; bit 6 = group 3 bits 15:0;
  - groups 4 to 10 use all 32 bits and drive bits 16, 17, 18, 20, 22, 23 and 30 respectively.
  - All other master bits below 31 read 0.
- R6: A master register write changes only bit 31, the global enable. Summary bits ignore written data.
- R7: `irq_pulse` is high for exactly one cycle. It goes high one clock edge after the condition (master bit 31 set AND any summary bit set AND message control valid) rises from 0 to 1. It stays low while the condition is held or false, and low whenever master bit 31 is 0.
- R8: The message control word is valid only when it equals 0x0001: enable bit 0 set and bits 15:1 all zero. Any other value suppresses the request.
- R9: Address map: group g occupies byte addresses g*16 + {0 status, 4 mask, 8 identity, 12 enable}, and the master register is at 0xB0. Accesses with address bits 1:0 non-zero, and reads of unmapped addresses, return 0 and change nothing. The status register returns the group's current event inputs and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (8) | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_in | input | 352 | Event pulses, group g on bits 32g+31 to 32g |
| msg_ctrl | input | 16 | Message control word (bit 0 enable, 15:1 must be 0) |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
A wrong identity bit shows up on the very next read of that group's identity register. In the same cycle it also shows in the master summary, because the summaries are combinational from the stored state. A summary bit that fails to clear would hold the request condition high. That blocks the rising edge the next event should create, so a missing pulse within two cycles exposes it. The mask and clear corner cases are observed through readback right after the offending cycle, including the same-cycle clear-versus-event collision. The gating of the request on the enable bit and on the message word is observed directly on `irq_pulse`, one edge after the condition changes.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [351:0]  evt_in,
  input  logic [15:0]   msg_ctrl,
  output logic          irq_pulse
);
  localparam int NGRP    = 11;
  localparam int DW      = 32;
  localparam int HALF    = DW / 2;
  localparam int GW      = AW - 4;
  localparam int MST_ADR = NGRP * 16;

  logic [DW-1:0] mask_r  [NGRP];
  logic [DW-1:0] ident_r [NGRP];
  logic [DW-1:0] en_r    [NGRP];
  logic [DW-1:0] evt_g   [NGRP];
  logic [DW-1:0] contrib [NGRP];
  logic          gen_en;
  logic [30:0]   summ;
  logic          cond, cond_d, irq_q;

  wire          aligned = (bus_addr[1:0] == 2'b00);
  wire [GW-1:0] sel_grp = bus_addr[AW-1:4];
  wire [1:0]    sel_reg = bus_addr[3:2];
  wire          is_mst  = aligned && (bus_addr == AW'(MST_ADR));

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : grp
      wire acc = bus_wr && aligned && (sel_grp == GW'(g));
      wire [DW-1:0] clr = (acc && sel_reg == 2'd2) ? bus_wdata : '0;

      assign evt_g[g]   = evt_in[g*DW +: DW];
      assign contrib[g] = ident_r[g] & en_r[g];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mask_r[g]  <= '1;
          ident_r[g] <= '0;
          en_r[g]    <= '0;
        end else begin
          ident_r[g] <= (ident_r[g] & ~clr) | (evt_g[g] & ~mask_r[g]);
          if (acc && sel_reg == 2'd1) mask_r[g] <= bus_wdata;
          if (acc && sel_reg == 2'd3) en_r[g]   <= bus_wdata;
        end
      end

      // R2
      masked_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~$past(ident_r[g]) & ident_r[g] & $past(mask_r[g])) == '0));

      // R3
      ident_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ident_r[g]) & ~ident_r[g]) != '0) |->
          $past(bus_wr && aligned && sel_grp == GW'(g) && sel_reg == 2'd2));
    end
  endgenerate

  always_comb begin
    summ     = '0;
    summ[0]  = |contrib[0][HALF-1:0];
    summ[1]  = |contrib[0][DW-1:HALF];
    summ[2]  = |contrib[1][HALF-1:0];
    summ[3]  = |contrib[1][DW-1:HALF];
    summ[4]  = |contrib[2][HALF-1:0];
    summ[6]  = |contrib[3][HALF-1:0];
    summ[16] = |contrib[4];
    summ[17] = |contrib[5];
    summ[18] = |contrib[6];
    summ[20] = |contrib[7];
    summ[22] = |contrib[8];
    summ[23] = |contrib[9];
    summ[30] = |contrib[10];
  end

  assign cond = gen_en && (|summ) && (msg_ctrl == 16'h0001);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      cond_d <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (bus_wr && is_mst) gen_en <= bus_wdata[31];
      cond_d <= cond;
      irq_q  <= cond && !cond_d;
    end
  end

  assign irq_pulse = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (is_mst)
      bus_rdata = {gen_en, summ};
    else if (aligned && sel_grp < GW'(NGRP)) begin
      case (sel_reg)
        2'd0:    bus_rdata = evt_g[sel_grp];
        2'd1:    bus_rdata = mask_r[sel_grp];
        2'd2:    bus_rdata = ident_r[sel_grp];
        default: bus_rdata = en_r[sel_grp];
      endcase
    end
  end

  // R6
  gen_en_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr && is_mst) |-> (gen_en == $past(gen_en)));

  // R7
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R8
  irq_needs_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(msg_ctrl == 16'h0001 && gen_en));
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [351:0] evt_in = '0;
  logic [15:0]  msg_ctrl = '0;
  logic         irq_pulse;
  int vecs = 0;
  int errs = 0;
  bit done = 0;

  irq_aggregator dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .msg_ctrl(msg_ctrl), .irq_pulse(irq_pulse));

  always #10 clk = ~clk;

  localparam logic [7:0] MST = 8'hB0;
  function automatic logic [7:0] ra(int g, int r);
    return 8'(g * 16 + r * 4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    bus_addr = a; #1; chk(req, bus_rdata, exp);
  endtask

  task automatic pulse(int g, logic [31:0] bits);
    @(negedge clk); evt_in[g*32 +: 32] = bits;
    @(negedge clk); evt_in = '0;
  endtask

  task automatic t_reset;
    rd("R1", ra(0,1), 32'hFFFF_FFFF);
    rd("R1", ra(10,1), 32'hFFFF_FFFF);
    rd("R1", ra(0,2), 0);
    rd("R1", ra(5,3), 0);
    rd("R1", MST, 0);
    chk("R1", 32'(irq_pulse), 0);
  endtask

  task automatic t_regs;
    wr(ra(0,1), 32'h1234_5678); rd("R4", ra(0,1), 32'h1234_5678);
    wr(ra(0,1), 32'h0000_0000); rd("R4", ra(0,1), 0);
    wr(ra(0,3), 32'hA5A5_0F0F); rd("R4", ra(0,3), 32'hA5A5_0F0F);
  endtask

  task automatic t_mask;
    pulse(1, 32'h1);
    rd("R2", ra(1,2), 0);
    wr(ra(1,1), 32'hFFFF_FFFE);
    rd("R2", ra(1,2), 0);
    pulse(1, 32'h3);
    rd("R2", ra(1,2), 32'h1);
    wr(ra(1,2), 32'hFFFF_FFFF);
  endtask

  task automatic t_summary;
    wr(ra(0,3), 32'h0001_0001);
    pulse(0, 32'h0000_0001); rd("R5", MST, 32'h1);
    pulse(0, 32'h0001_0000); rd("R5", MST, 32'h3);
    wr(ra(0,2), 32'h1);      rd("R5", MST, 32'h2);
    wr(ra(0,3), 32'h0);      rd("R5", MST, 32'h0);
    wr(ra(0,2), 32'hFFFF_FFFF);
    wr(ra(3,1), 0); wr(ra(3,3), 32'hFFFF_FFFF);
    pulse(3, 32'h8000_0000); rd("R5", MST, 32'h0);
    pulse(3, 32'h0000_0100); rd("R5", MST, 32'h40);
    wr(ra(3,2), 32'hFFFF_FFFF);
    wr(ra(10,1), 0); wr(ra(10,3), 32'h0400_0000);
    pulse(10, 32'h0400_0000); rd("R5", MST, 32'h4000_0000);
    wr(ra(10,2), 32'hFFFF_FFFF); rd("R5", MST, 0);
  endtask

  task automatic t_master;
    wr(MST, 32'hFFFF_FFFF); rd("R6", MST, 32'h8000_0000);
    wr(MST, 32'h7FFF_FFFF); rd("R6", MST, 32'h0);
  endtask

  task automatic t_irq;
    msg_ctrl = 16'h0001;
    wr(MST, 32'h8000_0000);
    wr(ra(4,1), 0); wr(ra(4,3), 32'hFFFF_FFFF);
    pulse(4, 32'h20);
    rd("R5", MST, 32'h8001_0000);
    chk("R7", 32'(irq_pulse), 0);
    @(negedge clk); chk("R7", 32'(irq_pulse), 1);
    @(negedge clk); chk("R7", 32'(irq_pulse), 0);
    pulse(4, 32'h40);
    @(negedge clk); chk("R7", 32'(irq_pulse), 0);
    // R3 clear plus same-cycle event on bit 5
    @(negedge clk); bus_addr = ra(4,2); bus_wdata = 32'h60; bus_wr = 1; evt_in[4*32 +: 32] = 32'h20;
    @(negedge clk); bus_wr = 0; evt_in = '0;
    rd("R3", ra(4,2), 32'h20);
    wr(ra(4,2), 32'h20); rd("R3", ra(4,2), 0);
  endtask

  task automatic t_gate;
    msg_ctrl = 16'h0003;
    pulse(4, 32'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R8", 32'(irq_pulse), 0);
    end
    msg_ctrl = 16'h0001;
    @(negedge clk); chk("R8", 32'(irq_pulse), 1);
    msg_ctrl = 16'h0000;
    wr(ra(4,2), 32'h1);
    pulse(4, 32'h2);
    @(negedge clk); chk("R8", 32'(irq_pulse), 0);
    wr(ra(4,2), 32'h2);
    msg_ctrl = 16'h0001;
    wr(MST, 0);
    pulse(4, 32'h4);
    rd("R7", MST, 32'h0001_0000);
    @(negedge clk); chk("R7", 32'(irq_pulse), 0);
    @(negedge clk); chk("R7", 32'(irq_pulse), 0);
  endtask

  task automatic t_map;
    @(negedge clk); evt_in[2*32 +: 32] = 32'hA5;
    rd("R9", ra(2,0), 32'hA5);
    evt_in = '0;
    wr(ra(2,0), 32'hFFFF_FFFF); rd("R9", ra(2,0), 0);
    wr(8'h05, 32'hDEAD_BEEF); rd("R9", ra(1,1), 32'hFFFF_FFFE);
    rd("R9", 8'h06, 0);
    rd("R9", 8'hC4, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_mask;
    t_summary;
    t_master;
    t_irq;
    t_gate;
    t_map;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule